// File: doc/BRIEF.md
# ADC Scan-Mode Channel Sequencer

This block decides which analog input a successive-approximation converter samples in each conversion slot of an automatic scan. A command byte is written into the block with a load strobe. The block keeps the byte in a command register and decodes two of its fields: a channel number N and a two-bit scan mode. The load also starts a sequence of conversion slots. In each slot the block presents a channel index. The conversion engine answers with a one-cycle next-conversion pulse when it has finished that slot, and the block then moves to the following slot.

The block also reports the number of conversions in the current plan, and raises a flag while the final slot is being served. Automatic scanning happens only when the command selects the internally timed conversion clock. With the externally timed clock, every command becomes a single conversion of channel N. A parameter selects an 8-input build or a 4-input build. In the 4-input build the top bit of the channel field is ignored.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the command register holds 0x06: channel 0, scan mode 00, external clock. The block is idle, `conv_total` is 1, `chan_idx` is 0 and `last_conv` is low.
- R2: A `cmd_load` pulse while idle stores `cmd_byte`, with channel N in bits 7..5, scan mode in bits 4..3 and the internal-clock select in bit 0 (1 = internal). From the next cycle the block is active in slot 0.
- R3: With internal clock and scan mode 00, the plan is one conversion of channel N, and `conv_total` is 1.
- R4: With internal clock and scan mode 01, the slots visit channels 0, 1, ... N in ascending order, and `conv_total` is N+1.
- R5: With internal clock and scan mode 10, and N at or above the half-point H (H = NUM_CH/2, so 4 in the 8-input build and 2 in the 4-input build), the slots visit H through N in ascending order, and `conv_total` is N-H+1.
- R6: With internal clock, scan mode 10 and N below H, the plan is one conversion of channel N.
- R7: With internal clock and scan mode 11, channel N is converted NUM_CH times in a row, and `conv_total` is NUM_CH.
- R8: With external clock (bit 0 = 0), the scan field is ignored and the plan is one conversion of channel N.
- R9: `last_conv` is high exactly during the final slot of a plan. A `conv_next` pulse in that slot returns the block to idle on the next cycle.
- R10: In the 4-input build (NUM_CH = 4), bit 7 of the command is ignored, and the channel is taken from bits 6..5.
- R11: While active, a `cmd_load` pulse is ignored: the plan, the total and the slot sequence carry on unchanged. While idle, `conv_next` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_load | input | 1 | Strobe: store `cmd_byte` and start a plan |
| cmd_byte | input | 8 | Command byte (channel 7..5, scan 4..3, clock select 0) |
| conv_next | input | 1 | Pulse: current slot's conversion is finished |
| seq_active | output | 1 | A plan is in progress |
| chan_idx | output | $clog2(NUM_CH) | Channel to convert in the current slot |
| last_conv | output | 1 | Current slot is the final one |
| conv_total | output | $clog2(NUM_CH+1) | Number of conversions in the stored plan |

## Verification
Two functions can meet in the same cycle: the completion handshake of the final slot, and a new command load. Since the block is still active in that cycle, the load must be dropped. The bench drives both pulses together on the last slot of an ascending scan. It then checks that the block is idle on the next cycle and that `conv_total` still reports the old plan rather than the rejected command. Separately, a load in the middle of a plan is checked to leave the channel order undisturbed.

// File: rtl/adc_scan_pkg.sv
// Package: shared field positions, scan-mode encoding and reset value
// for the scan-mode channel sequencer.
package adc_scan_pkg;

    typedef enum logic [1:0] {
        SCAN_ONE    = 2'b00,
        SCAN_UPTO   = 2'b01,
        SCAN_UPPER  = 2'b10,
        SCAN_REPEAT = 2'b11
    } scan_e;

    localparam int CMD_W        = 8;
    localparam int CH_LSB       = 5;
    localparam int SCAN_LSB     = 3;
    localparam int CLK_SEL_BIT  = 0;
    localparam logic [CMD_W-1:0] CMD_RESET = 8'h06;

endpackage

// File: rtl/scan_cmd_reg.sv
// Command register: holds the last accepted command byte.
// Assumes the caller gates load_en so that loads during a plan are dropped.
module scan_cmd_reg
    import adc_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CMD_W-1:0] cmd_in,
    output logic [CMD_W-1:0] cmd_q
);

    // Store the command on an accepted load; reset to the power-on value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= CMD_RESET;
        else if (load_en)
            cmd_q <= cmd_in;
    end

endmodule

// File: rtl/scan_plan.sv
// Scan planner: decodes the stored command into the first channel, the
// number of conversions and whether the channel repeats. Pure logic.
// Assumes NUM_CH is a power of two of at least 4.
module scan_plan
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CW = $clog2(NUM_CH),
    localparam int TW = $clog2(NUM_CH + 1)
) (
    input  logic [CMD_W-1:0] cmd_q,
    output logic [CW-1:0]    first_ch,
    output logic [TW-1:0]    total,
    output logic             repeat_ch
);

    localparam logic [CW-1:0] HALF = CW'(NUM_CH / 2);

    logic [CW-1:0] sel_ch;
    scan_e         mode;
    logic          int_clk;

    // Field extraction; the channel width drops unused top bits in small builds.
    always_comb begin
        sel_ch  = cmd_q[CH_LSB +: CW];
        mode    = scan_e'(cmd_q[SCAN_LSB +: 2]);
        int_clk = cmd_q[CLK_SEL_BIT];
    end

    // Plan decode: single conversion unless an internal-clock scan applies.
    always_comb begin
        first_ch  = sel_ch;
        total     = TW'(1);
        repeat_ch = 1'b0;
        if (int_clk) begin
            case (mode)
                SCAN_UPTO: begin
                    first_ch = '0;
                    total    = TW'(sel_ch) + TW'(1);
                end
                SCAN_UPPER: begin
                    if (sel_ch >= HALF) begin
                        first_ch = HALF;
                        total    = TW'(sel_ch) - TW'(HALF) + TW'(1);
                    end
                end
                SCAN_REPEAT: begin
                    repeat_ch = 1'b1;
                    total     = TW'(NUM_CH);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/scan_slot_ctr.sv
// Slot counter: tracks the active plan and the current slot number.
// Assumes total is at least 1 and stays stable while active.
module scan_slot_ctr #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          advance,
    input  logic [TW-1:0] total,
    output logic          active,
    output logic [TW-1:0] slot,
    output logic          last
);

    // Final-slot detect.
    always_comb last = active && (slot == total - TW'(1));

    // Slot progression: start at 0, step on handshake, go idle after the final slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            slot   <= '0;
        end else if (start) begin
            active <= 1'b1;
            slot   <= '0;
        end else if (active && advance) begin
            if (last) begin
                active <= 1'b0;
                slot   <= '0;
            end else begin
                slot <= slot + TW'(1);
            end
        end
    end

endmodule

// File: rtl/adc_scan_seq.sv
// Top: scan-mode channel sequencer. A command load starts a plan. Each
// conv_next pulse advances one slot, and the block goes idle after the
// final slot. Assumes conv_next is a single-cycle pulse per conversion.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CW = $clog2(NUM_CH),
    localparam int TW = $clog2(NUM_CH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_load,
    input  logic [7:0]    cmd_byte,
    input  logic          conv_next,
    output logic          seq_active,
    output logic [CW-1:0] chan_idx,
    output logic          last_conv,
    output logic [TW-1:0] conv_total
);

    logic [CMD_W-1:0] cmd_q;
    logic [CW-1:0]    first_ch;
    logic [TW-1:0]    total;
    logic             repeat_ch;
    logic             active;
    logic [TW-1:0]    slot;
    logic             last;
    logic             accept;

    // Loads are taken only between plans.
    always_comb accept = cmd_load && !active;

    scan_cmd_reg u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (accept),
        .cmd_in  (cmd_byte),
        .cmd_q   (cmd_q)
    );

    scan_plan #(.NUM_CH(NUM_CH)) u_plan (
        .cmd_q     (cmd_q),
        .first_ch  (first_ch),
        .total     (total),
        .repeat_ch (repeat_ch)
    );

    scan_slot_ctr #(.TW(TW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .advance (conv_next),
        .total   (total),
        .active  (active),
        .slot    (slot),
        .last    (last)
    );

    // Channel of the current slot: fixed when repeating, else first plus slot.
    always_comb begin
        if (repeat_ch)
            chan_idx = first_ch;
        else
            chan_idx = first_ch + slot[CW-1:0];
    end

    // Output drive.
    always_comb begin
        seq_active = active;
        last_conv  = last;
        conv_total = total;
    end

endmodule

// File: rtl/adc_scan_seq_chk.sv
// Checker for adc_scan_seq: port-level temporal properties, bound to every instance.
module adc_scan_seq_chk #(
    parameter int NUM_CH = 8,
    localparam int CW = $clog2(NUM_CH),
    localparam int TW = $clog2(NUM_CH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_load,
    input logic          conv_next,
    input logic          seq_active,
    input logic [CW-1:0] chan_idx,
    input logic          last_conv,
    input logic [TW-1:0] conv_total
);

    a_r9_last_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        last_conv |-> seq_active);

    a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active && last_conv && conv_next |=> !seq_active);

    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_active && cmd_load |=> seq_active);

    a_r11_total_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active |=> $stable(conv_total));

    a_r11_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active && !conv_next |=> $stable(chan_idx) && seq_active);

    a_r11_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_active && !cmd_load |=> !seq_active);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_load   (cmd_load),
    .conv_next  (conv_next),
    .seq_active (seq_active),
    .chan_idx   (chan_idx),
    .last_conv  (last_conv),
    .conv_total (conv_total)
);

// File: tb/adc_scan_seq_test.sv
// Bench: table-driven plan walks on an 8-input and a 4-input build,
// then directed reset and collision cases.
module adc_scan_seq_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       ld8 = 0, nx8 = 0, ld4 = 0, nx4 = 0;
    logic [7:0] cmd = 8'h00;
    logic       act8, last8, act4, last4;
    logic [2:0] ch8;
    logic [3:0] tot8;
    logic [1:0] ch4;
    logic [2:0] tot4;

    adc_scan_seq #(.NUM_CH(8)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_load(ld8), .cmd_byte(cmd), .conv_next(nx8),
        .seq_active(act8), .chan_idx(ch8), .last_conv(last8), .conv_total(tot8));

    adc_scan_seq #(.NUM_CH(4)) uut4 (
        .clk(clk), .rst_n(rst_n), .cmd_load(ld4), .cmd_byte(cmd), .conv_next(nx4),
        .seq_active(act4), .chan_idx(ch4), .last_conv(last4), .conv_total(tot4));

    logic sel = 0;
    int   total = 0, bad = 0;
    bit   done = 0;

    function automatic int o_act();  return sel ? int'(act4)  : int'(act8);  endfunction
    function automatic int o_ch();   return sel ? int'(ch4)   : int'(ch8);   endfunction
    function automatic int o_last(); return sel ? int'(last4) : int'(last8); endfunction
    function automatic int o_tot();  return sel ? int'(tot4)  : int'(tot8);  endfunction

    task automatic chk(input int act, input int exp, input string tag, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic pulse_load(input logic [7:0] c);
        @(negedge clk);
        cmd = c;
        if (sel) ld4 = 1; else ld8 = 1;
        @(negedge clk);
        ld4 = 0; ld8 = 0;
    endtask

    task automatic pulse_next();
        if (sel) nx4 = 1; else nx8 = 1;
        @(negedge clk);
        nx4 = 0; nx8 = 0;
    endtask

    // Table columns: build(1=4-input), ch, scan, clk sel, total, first, step.
    localparam int NV = 13;
    localparam int V_SEL  [NV] = '{0,0,0,0,0,0,0,0,0,1,1,1,1};
    localparam int V_CH   [NV] = '{5,3,7,6,4,2,3,6,0,7,6,3,1};
    localparam int V_SCAN [NV] = '{0,1,1,2,2,2,3,1,1,1,3,2,2};
    localparam int V_CLK  [NV] = '{1,1,1,1,1,1,1,0,1,1,1,1,1};
    localparam int V_TOT  [NV] = '{1,4,8,3,1,1,8,1,1,4,4,2,1};
    localparam int V_FST  [NV] = '{5,0,0,4,4,2,3,6,0,0,2,2,1};
    localparam int V_STEP [NV] = '{1,1,1,1,1,1,0,1,1,1,0,1,1};
    string tags [NV];

    initial begin
        tags = '{"R3","R4","R4","R5","R5","R6","R7","R8","R4","R10","R10","R5","R6"};

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state on both builds.
        chk(int'(act8), 0, "R1", "active8");
        chk(int'(tot8), 1, "R1", "total8");
        chk(int'(ch8),  0, "R1", "chan8");
        chk(int'(last8), 0, "R1", "last8");
        chk(int'(tot4), 1, "R1", "total4");

        for (int v = 0; v < NV; v++) begin
            sel = V_SEL[v][0];
            pulse_load({V_CH[v][2:0], V_SCAN[v][1:0], 2'b11, V_CLK[v][0]});
            chk(o_act(), 1, "R2", "active after load");
            chk(o_tot(), V_TOT[v], tags[v], "total");
            for (int s = 0; s < V_TOT[v]; s++) begin
                chk(o_ch(), V_FST[v] + V_STEP[v] * s, tags[v], "chan");
                chk(o_last(), (s == V_TOT[v] - 1) ? 1 : 0, "R9", "last flag");
                pulse_next();
            end
            chk(o_act(), 0, "R9", "idle after final slot");
        end

        // R11: load during a plan ignored; sequence carries on.
        sel = 0;
        pulse_load({3'd3, 2'b01, 2'b11, 1'b1});
        pulse_next();
        pulse_load({3'd7, 2'b11, 2'b11, 1'b1});
        chk(int'(tot8), 4, "R11", "total after mid-plan load");
        chk(int'(ch8),  1, "R11", "chan after mid-plan load");
        pulse_next();
        chk(int'(ch8), 2, "R11", "chan advances");
        pulse_next();
        chk(int'(last8), 1, "R9", "last on slot 3");
        // Final handshake and a new load in the same cycle: load dropped.
        cmd = {3'd6, 2'b11, 2'b11, 1'b1};
        ld8 = 1; nx8 = 1;
        @(negedge clk);
        ld8 = 0; nx8 = 0;
        chk(int'(act8), 0, "R11", "idle after collision");
        chk(int'(tot8), 4, "R11", "total after collision");

        // R11: conv_next while idle has no effect.
        pulse_next();
        chk(int'(act8), 0, "R11", "idle next active");
        chk(int'(ch8),  0, "R11", "idle next chan");

        // R1: reset in mid-plan returns to idle and default command.
        pulse_load({3'd5, 2'b11, 2'b11, 1'b1});
        pulse_next();
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(int'(act8), 0, "R1", "active after reset");
        chk(int'(tot8), 1, "R1", "total after reset");
        chk(int'(ch8),  0, "R1", "chan after reset");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule